// File: doc/BRIEF.md
# SPI Byte Shifter with Power-of-Two Clock Divider

This block is the serial core of an SPI host. It exchanges one byte full duplex over a clock, a data-out and a data-in line. Each byte takes eight clock periods. The serial clock comes from the base clock through a divider whose ratio is a power of two, chosen by a 4-bit code. The code spans ratios from /2 up to /65536. All four combinations of clock polarity and clock phase are supported.

A controller drives a one-cycle start pulse together with the transmit byte, the divider code and the two mode bits. The block samples these values when it accepts the start. It holds `busy_o` high until the last bit has been captured and one further half period of the serial clock has passed. After that, the received byte waits on `rx_byte_o` until the next transfer changes it. Chip-select control, register access and framing across several bytes belong to the surrounding logic.

Top module: `spi_byte_engine`

## Requirements
- R1: With divider code n (0..15), every serial clock level lasts exactly 2^n base clock cycles, so the serial clock runs at the base clock divided by 2^(n+1).
- R2: While idle, `sclk_o` holds the `cpol_i` value sampled at the previous base clock edge. After the last edge of a transfer, `sclk_o` is back at the latched polarity when `busy_o` falls.
- R3: With phase 0 (`cpha_i`=0), `mosi_o` carries the first data bit from the cycle after start, before any clock edge. Data-in is sampled on edges 1, 3, 5, …, 15, and `mosi_o` changes only on edges 2, 4, …, 16.
- R4: With phase 1 (`cpha_i`=1), `mosi_o` changes on edges 1, 3, …, 15, the first edge putting out the first data bit. Data-in is sampled on edges 2, 4, …, 16.
- R5: Each transfer shifts exactly 8 bits out and 8 bits in, most significant bit first. The first bit received lands in `rx_byte_o[7]`. `rx_byte_o` holds the full received byte once `busy_o` is low.
- R6: A start is accepted when `start_i` is high while `busy_o` is low, and `busy_o` is high from the next cycle. Counting from the accepting edge, edge k of the serial clock (k = 1..16) occurs k·2^n cycles later, and `busy_o` falls 17·2^n cycles later.
- R7: The divider code and both mode bits are taken at the accepting edge. Later changes on `div_code_i`, `cpol_i` or `cpha_i` do not alter the transfer in progress.
- R8: A start pulse while `busy_o` is high is ignored. Timing, transmitted bits and the received byte stay those of the running transfer.
- R9: After reset, `busy_o`, `sclk_o`, `mosi_o` and `rx_byte_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for one byte |
| tx_byte_i | input | 8 | Byte to transmit |
| div_code_i | input | 4 | Divider code n, ratio 2^(n+1) |
| cpol_i | input | 1 | Clock polarity (idle level) |
| cpha_i | input | 1 | Clock phase (0: sample on first edge, 1: on second) |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer in progress |
| rx_byte_o | output | 8 | Received byte, valid while not busy |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |

## Verification
Everything is timed from the base clock edge that accepts a start. Serial edge k is due k·2^n cycles after that edge, and `busy_o` falls, with the received byte in place, 17·2^n cycles after it. Idle clock level follows polarity with one cycle of delay. The bench model records the accepting edge and its latched settings, and computes every expected value from the elapsed cycle count. It compares `busy_o` and `sclk_o` on the falling edge of every base clock cycle. It checks `mosi_o` on the cycle just after each sampling edge and `rx_byte_o` on the cycle just after `busy_o` falls. Its slave drives each input bit half a base cycle before the edge that samples it.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

   // Clock mode of one transfer, latched at start
   typedef struct packed {
      logic cpol;
      logic cpha;
   } spi_mode_t;

endpackage

// File: rtl/spi_div_tick.sv
// Half-period prescaler: tick every 2^code cycles while running
module spi_div_tick #(
   parameter int CODE_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              run_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              tick_o
);
   localparam int CNT_W = (1 << CODE_W) - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   always_comb begin
      limit  = {CNT_W{1'b1}} >> (CNT_W - int'(code_i));
      tick_o = run_i && (cnt_q == limit);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/spi_edge_seq.sv
// Serial clock edge sequencer: 2*DATA_W edges plus one trailing half period
module spi_edge_seq #(
   parameter int DATA_W = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic cpol_i,
   input  logic cpha_i,
   input  logic tick_i,
   output logic sclk_o,
   output logic busy_o,
   output logic sample_o,
   output logic drive_o
);
   localparam int EDGES = 2 * DATA_W;
   localparam int EC_W  = $clog2(EDGES + 1);

   logic [EC_W-1:0] edge_q;
   logic            busy_q;
   logic            sclk_q;
   logic            edge_now;

   always_comb begin
      edge_now = busy_q && tick_i && (edge_q != EC_W'(EDGES));
      sample_o = edge_now && (edge_q[0] == cpha_i);
      drive_o  = edge_now && (edge_q[0] != cpha_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         edge_q <= '0;
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
      end else if (!busy_q) begin
         sclk_q <= cpol_i;
         if (load_i) begin
            busy_q <= 1'b1;
            edge_q <= '0;
         end
      end else if (tick_i) begin
         if (edge_q == EC_W'(EDGES)) begin
            busy_q <= 1'b0;
         end else begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
         end
      end
   end

   assign sclk_o = sclk_q;
   assign busy_o = busy_q;
endmodule

// File: rtl/spi_shifter.sv
// Transmit and receive shift registers with selectable bit order
module spi_shifter #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] tx_i,
   input  logic              cpha_i,
   input  logic              sample_i,
   input  logic              drive_i,
   input  logic              miso_i,
   output logic              mosi_o,
   output logic [DATA_W-1:0] rx_o
);
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic              mosi_q;
   logic              load_head;
   logic [DATA_W-1:0] load_rest;
   logic              tx_head;
   logic [DATA_W-1:0] tx_rest;
   logic [DATA_W-1:0] rx_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign load_head = tx_i[DATA_W-1];
         assign load_rest = {tx_i[DATA_W-2:0], 1'b0};
         assign tx_head   = tx_q[DATA_W-1];
         assign tx_rest   = {tx_q[DATA_W-2:0], 1'b0};
         assign rx_next   = {rx_q[DATA_W-2:0], miso_i};
      end else begin : g_lsb
         assign load_head = tx_i[0];
         assign load_rest = {1'b0, tx_i[DATA_W-1:1]};
         assign tx_head   = tx_q[0];
         assign tx_rest   = {1'b0, tx_q[DATA_W-1:1]};
         assign rx_next   = {miso_i, rx_q[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_q   <= '0;
         rx_q   <= '0;
         mosi_q <= 1'b0;
      end else begin
         if (load_i) begin
            if (!cpha_i) begin
               mosi_q <= load_head;
               tx_q   <= load_rest;
            end else begin
               tx_q   <= tx_i;
            end
         end else if (drive_i) begin
            mosi_q <= tx_head;
            tx_q   <= tx_rest;
         end
         if (sample_i) begin
            rx_q <= rx_next;
         end
      end
   end

   assign mosi_o = mosi_q;
   assign rx_o   = rx_q;
endmodule

// File: rtl/spi_byte_engine.sv
// One-byte full-duplex SPI engine, clock divided by 2^(code+1)
module spi_byte_engine
   import spi_byte_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DIV_CODE_W = 4,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic [DIV_CODE_W-1:0] div_code_i,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic              miso_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              sclk_o,
   output logic              mosi_o
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_byte_engine: DATA_W must be at least 2");
      end
      if (DIV_CODE_W < 1 || DIV_CODE_W > 5) begin : g_bad_code
         $error("spi_byte_engine: DIV_CODE_W must lie in 1..5");
      end
   endgenerate

   spi_mode_t             mode_q;
   logic [DIV_CODE_W-1:0] div_q;
   logic                  busy;
   logic                  accept;
   logic                  div_tick;
   logic                  smp;
   logic                  drv;

   assign accept = start_i && !busy;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= '0;
         div_q  <= '0;
      end else if (accept) begin
         mode_q <= '{cpol: cpol_i, cpha: cpha_i};
         div_q  <= div_code_i;
      end
   end

   spi_div_tick #(.CODE_W(DIV_CODE_W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (accept),
      .run_i   (busy),
      .code_i  (div_q),
      .tick_o  (div_tick)
   );

   spi_edge_seq #(.DATA_W(DATA_W)) u_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (accept),
      .cpol_i   (cpol_i),
      .cpha_i   (mode_q.cpha),
      .tick_i   (div_tick),
      .sclk_o   (sclk_o),
      .busy_o   (busy),
      .sample_o (smp),
      .drive_o  (drv)
   );

   spi_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (accept),
      .tx_i     (tx_byte_i),
      .cpha_i   (cpha_i),
      .sample_i (smp),
      .drive_i  (drv),
      .miso_i   (miso_i),
      .mosi_o   (mosi_o),
      .rx_o     (rx_byte_o)
   );

   assign busy_o = busy;
endmodule

// File: rtl/spi_byte_engine_chk.sv
module spi_byte_engine_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic start_i,
   input logic busy_o,
   input logic sclk_o,
   input logic mosi_o,
   input logic tick_i,
   input logic sample_i,
   input logic drive_i,
   input logic cpol_q_i
);
   // R6
   busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o) |=> busy_o);

   // R6
   busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !tick_i) |=> busy_o);

   // R1
   sclk_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !tick_i) |=> $stable(sclk_o));

   // R3
   mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_i |=> $stable(mosi_o));

   // R4
   strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({sample_i, drive_i}));

   // R2
   idle_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> (sclk_o == cpol_q_i));
endmodule

bind spi_byte_engine spi_byte_engine_chk u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .start_i  (start_i),
   .busy_o   (busy_o),
   .sclk_o   (sclk_o),
   .mosi_o   (mosi_o),
   .tick_i   (div_tick),
   .sample_i (smp),
   .drive_i  (drv),
   .cpol_q_i (mode_q.cpol)
);

// File: tb/spi_byte_engine_bench.sv
`timescale 1ns/1ps
module spi_byte_engine_bench;
   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] tx_byte_i = 8'h00;
   logic [3:0] div_code_i = 4'h0;
   logic       cpol_i = 1'b0;
   logic       cpha_i = 1'b0;
   logic       miso_i = 1'b0;
   logic       busy_o;
   logic [7:0] rx_byte_o;
   logic       sclk_o;
   logic       mosi_o;

   int checks = 0;
   int errors = 0;
   string note = "";

   // reference model state
   int       cyc = 0;
   int       c0 = 0;
   int       half = 1;
   bit       active = 0;
   bit       m_busy = 0;
   bit       idle_lvl = 0;
   bit       l_cpol = 0;
   bit       l_cpha = 0;
   bit [7:0] l_tx = 0;
   bit [7:0] l_rx = 0;
   bit [7:0] rx_pat = 0;
   int       wd = 0;

   always #2.5 clk_i = ~clk_i;

   spi_byte_engine u_spi_byte_engine (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tx_byte_i(tx_byte_i),
      .div_code_i(div_code_i), .cpol_i(cpol_i), .cpha_i(cpha_i), .miso_i(miso_i),
      .busy_o(busy_o), .rx_byte_o(rx_byte_o), .sclk_o(sclk_o), .mosi_o(mosi_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, note, act, exp);
      end
   endtask

   // model update on each base clock edge
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         active = 0; m_busy = 0; idle_lvl = 0; cyc = 0;
      end else begin
         cyc++;
         if (!m_busy && start_i) begin
            c0 = cyc; half = 1 << div_code_i; active = 1;
            l_cpol = cpol_i; l_cpha = cpha_i; l_tx = tx_byte_i; l_rx = rx_pat;
            idle_lvl = cpol_i;
         end else if (!m_busy) begin
            idle_lvl = cpol_i;
         end
         m_busy = active && ((cyc - c0) < 17 * half);
      end
   end

   // compare away from the active edge and drive the slave data
   always @(negedge clk_i) begin
      if (rst_ni) begin
         int t, k, sd;
         bit in_x;
         t = cyc - c0;
         in_x = active && (t < 17 * half);
         k = in_x ? ((t / half > 16) ? 16 : t / half) : 0;
         sd = l_cpha ? k / 2 : (k + 1) / 2;
         if (sd > 8) sd = 8;
         chk(busy_o == in_x, "R6", busy_o, in_x);
         chk(sclk_o == (in_x ? (l_cpol ^ k[0]) : idle_lvl), "R1", sclk_o,
             in_x ? (l_cpol ^ k[0]) : idle_lvl);
         // R3 / R4: data-out seen at each sampling edge
         if (in_x && k >= 1 && k <= 16 && t == k * half && (k[0] != l_cpha))
            chk(mosi_o == l_tx[8 - sd], l_cpha ? "R4" : "R3", mosi_o, l_tx[8 - sd]);
         // R3: first bit present before any edge with phase 0
         if (in_x && t == 0 && !l_cpha)
            chk(mosi_o == l_tx[7], "R3", mosi_o, l_tx[7]);
         // R5: received byte when busy falls
         if (active && t == 17 * half)
            chk(rx_byte_o == l_rx, "R5", rx_byte_o, l_rx);
         miso_i <= (in_x && sd < 8) ? l_rx[7 - sd] : 1'b0;
      end
   end

   always @(posedge clk_i) begin
      wd++;
      if (wd > 60000) begin
         errors++;
         $display("FAIL R6 watchdog expired: actual %0d expected <= 60000", wd);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic xfer(input int code, input bit pol, input bit pha,
                       input bit [7:0] tx, input bit [7:0] rxp, input string n);
      @(negedge clk_i);
      note = n;
      div_code_i = code[3:0]; cpol_i = pol; cpha_i = pha;
      tx_byte_i = tx; rx_pat = rxp; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      while (m_busy) @(negedge clk_i);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      // R9: reset state
      note = "reset";
      chk(busy_o == 1'b0, "R9", busy_o, 0);
      chk(sclk_o == 1'b0, "R9", sclk_o, 0);
      chk(mosi_o == 1'b0, "R9", mosi_o, 0);
      chk(rx_byte_o == 8'h00, "R9", rx_byte_o, 0);
      rst_ni = 1'b1;
      repeat (3) @(negedge clk_i);
      // R2: idle level follows polarity
      cpol_i = 1'b1;
      repeat (3) @(negedge clk_i);
      cpol_i = 1'b0;
      repeat (2) @(negedge clk_i);

      xfer(0, 0, 0, 8'hA5, 8'h3C, "mode0 div/2");
      xfer(1, 0, 1, 8'h96, 8'hC3, "mode1 div/4");
      xfer(2, 1, 0, 8'h01, 8'h80, "mode2 div/8");
      xfer(3, 1, 1, 8'hFE, 8'h7F, "mode3 div/16");
      xfer(0, 1, 1, 8'h5A, 8'hE1, "mode3 div/2");
      xfer(0, 0, 0, 8'h00, 8'hFF, "back-to-back");

      // R7 / R8: inputs change and start repeats mid-transfer
      @(negedge clk_i);
      note = "R7 R8 div/32";
      div_code_i = 4'd4; cpol_i = 0; cpha_i = 1;
      tx_byte_i = 8'hC9; rx_pat = 8'h6B; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (40) @(negedge clk_i);
      div_code_i = 4'd0; cpol_i = 1; cpha_i = 0; tx_byte_i = 8'h12;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      while (m_busy) @(negedge clk_i);
      repeat (4) @(negedge clk_i);
      cpol_i = 0;
      repeat (3) @(negedge clk_i);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule